// File: doc/BRIEF.md
# Debounced GPIO Bank with Edge Interrupts

This block is a bank of fifteen general-purpose pins. Each pin can be set as an input or an output on its own. The pad is modelled as three separate signals: an incoming level, an outgoing level and an output enable. Every incoming level first passes through a two-flop synchronizer. It then passes through a debounce filter that advances only on cycles where an external tick enable is high. The filtered level changes only after the synchronized level has disagreed with it on three consecutive ticks.

The filtered levels are what software reads back, for input and output pins alike. They also feed per-pin edge detectors. Each detector watches for either a rising or a falling transition, as chosen per pin. A detected edge sets a sticky status bit, which is cleared by writing a one to it. The interrupt output is high while any status bit whose enable is set is high.

A simple register port gives access to direction, output data, filtered input, edge polarity, interrupt enable and status. Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the address.

Top module: `gpio_debounce_bank`

## Requirements
- R1: Register addresses are 0 direction (1 = output), 1 output data, 2 filtered input (read-only), 3 edge polarity, 4 interrupt enable and 5 status. Unused addresses read as zero. A write lands on the clock edge where `reg_we` is high.
- R2: `pad_oe` equals the direction register and `pad_out` equals the output-data register.
- R3: Once the synchronized level differs from the filtered level, the filtered level takes the new value on the third tick. It does not change on the second.
- R4: A disagreement that ends before the third tick restarts the count and leaves the filtered level unchanged.
- R5: The filtered level never changes on a cycle without a tick, however long the pad level has differed.
- R6: A polarity bit of 0 selects a rising edge and 1 selects a falling edge of the filtered level. A matching edge sets that pin's status bit. The bit stays set until it is cleared.
- R7: Writing to the status address clears each bit written as 1. An edge arriving in the same cycle as the clear leaves its bit set.
- R8: `irq` is high exactly when some status bit has its interrupt-enable bit set. A status bit whose enable is clear has no effect on `irq`.
- R9: Reading the filtered-input address returns the filtered level of every pin. For an output pin, this is the level present on the pad.
- R10: After reset, all pins are inputs, output data is 0, interrupts are disabled, polarity is rising and status is 0. The filtered level starts at the synchronized pad level, with no startup edge and no tick needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle debounce tick enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 15 | Register write data |
| reg_rdata | output | 15 | Register read data |
| pad_in | input | 15 | Level seen at each pad |
| pad_out | output | 15 | Level driven to each pad |
| pad_oe | output | 15 | Output enable of each pad |
| irq | output | 1 | Combined interrupt |

## Verification
A status clear written by software and a new edge on the same pin can fall in the same clock edge. The bench provokes this by holding the tick low and then pulsing it for exactly three cycles. It then places a one-to-clear write to that pin's status bit on the very next edge, which is the edge where the edge detector fires. Reading the status afterwards must show the bit still set, and a second, ordinary clear must then remove it.

// File: rtl/gpio_debounce_bank.sv
module gpio_debounce_bank #(
  parameter int N        = 15,
  parameter int DB_TICKS = 3,
  parameter int SYNC     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [N-1:0] reg_wdata,
  output logic [N-1:0] reg_rdata,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe,
  output logic         irq
);
  localparam int CW = $clog2(DB_TICKS + 1);
  localparam int IW = $clog2(SYNC + 2);
  localparam logic [2:0] A_DIR = 3'd0, A_OUT = 3'd1, A_IN = 3'd2,
                         A_POL = 3'd3, A_IE  = 3'd4, A_ST = 3'd5;

  logic [N-1:0] dir_q, out_q, pol_q, ie_q, st_q;
  logic [N-1:0] sync_q [SYNC];
  logic [N-1:0] filt_q, prev_q, evt, clr;
  logic [CW-1:0] cnt_q [N];
  logic [IW-1:0] init_q;
  logic init_done;

  assign init_done = (init_q == IW'(SYNC + 1));
  assign pad_oe  = dir_q;
  assign pad_out = out_q;
  assign evt = init_done ? ((filt_q & ~prev_q & ~pol_q) | (~filt_q & prev_q & pol_q)) : '0;
  assign clr = (reg_we && reg_addr == A_ST) ? reg_wdata : '0;
  assign irq = |(st_q & ie_q);

  always_comb begin
    case (reg_addr)
      A_DIR:   reg_rdata = dir_q;
      A_OUT:   reg_rdata = out_q;
      A_IN:    reg_rdata = filt_q;
      A_POL:   reg_rdata = pol_q;
      A_IE:    reg_rdata = ie_q;
      A_ST:    reg_rdata = st_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; out_q <= '0; pol_q <= '0; ie_q <= '0; st_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_DIR) dir_q <= reg_wdata;
      if (reg_we && reg_addr == A_OUT) out_q <= reg_wdata;
      if (reg_we && reg_addr == A_POL) pol_q <= reg_wdata;
      if (reg_we && reg_addr == A_IE)  ie_q  <= reg_wdata;
      st_q <= (st_q & ~clr) | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC; s++) sync_q[s] <= '0;
      init_q <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int s = 1; s < SYNC; s++) sync_q[s] <= sync_q[s-1];
      if (!init_done) init_q <= init_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= '0;
      prev_q <= '0;
      for (int i = 0; i < N; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!init_done) begin
          filt_q[i] <= sync_q[SYNC-1][i];
          prev_q[i] <= sync_q[SYNC-1][i];
          cnt_q[i]  <= '0;
        end else begin
          prev_q[i] <= filt_q[i];
          if (sync_q[SYNC-1][i] == filt_q[i]) begin
            cnt_q[i] <= '0;
          end else if (tick) begin
            if (cnt_q[i] == CW'(DB_TICKS - 1)) begin
              filt_q[i] <= sync_q[SYNC-1][i];
              cnt_q[i]  <= '0;
            end else begin
              cnt_q[i] <= cnt_q[i] + 1'b1;
            end
          end
        end
      end
    end
  end

  a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DIR) |=> (pad_oe == $past(reg_wdata)));

  a_r5_change_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(init_done) && filt_q != $past(filt_q)) |-> $past(tick));

  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_ST) |=> (($past(st_q) & ~st_q) == '0));

  a_r7_clear_unless_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_ST) |=> ((st_q & $past(reg_wdata) & ~$past(evt)) == '0));

  a_r8_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq);

  a_r10_no_startup_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> (st_q == '0));
endmodule

// File: tb/gpio_debounce_bank_test.sv
module gpio_debounce_bank_test;
  logic clk = 0, rst_n = 0, tick = 0, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [14:0] reg_wdata = 0, ext = 0;
  logic [14:0] reg_rdata, pad_in, pad_out, pad_oe;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_debounce_bank uut (.clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  // {dir, out, ext, expected filtered input}
  localparam logic [59:0] VEC [4] = '{
    {15'h0000, 15'h0000, 15'h7FFF, 15'h7FFF},
    {15'h00FF, 15'h00F0, 15'h7F0F, 15'h7FF0},
    {15'h7FFF, 15'h5555, 15'h0000, 15'h5555},
    {15'h5555, 15'h7FFF, 15'h2AAA, 15'h7FFF}
  };

  task automatic chk(input string tag, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [14:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [14:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [14:0] v;
    ext = 15'h1234;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (5) @(posedge clk);
    // R10 reset state, filtered level equals pad without ticks, no startup edge
    rd(3'd2, v); chk("R10 input after reset", v, 15'h1234);
    rd(3'd5, v); chk("R10 status after reset", v, 15'h0000);
    rd(3'd3, v); chk("R10 polarity after reset", v, 15'h0000);
    rd(3'd4, v); chk("R10 enable after reset", v, 15'h0000);
    chk("R10 pad_oe after reset", pad_oe, 15'h0000);
    chk("R10 pad_out after reset", pad_out, 15'h0000);
    chk("R10 irq after reset", {14'b0, irq}, 15'h0000);
    rd(3'd7, v); chk("R1 unused address", v, 15'h0000);

    for (int k = 0; k < 4; k++) begin
      ext = VEC[k][29:15];
      wr(3'd0, VEC[k][59:45]);
      wr(3'd1, VEC[k][44:30]);
      ticks(10);
      chk("R2 pad_oe", pad_oe, VEC[k][59:45]);
      chk("R2 pad_out", pad_out, VEC[k][44:30]);
      rd(3'd2, v); chk("R9 filtered readback", v, VEC[k][14:0]);
    end

    wr(3'd0, 15'h0000); ext = 15'h0000; ticks(10);
    wr(3'd5, 15'h7FFF);
    rd(3'd5, v); chk("R7 clear all", v, 15'h0000);

    // R3 and R7: exact third tick, clear colliding with edge
    @(negedge clk); ext[5] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); tick = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); reg_addr = 3'd2; #1 chk("R3 unchanged after two ticks", reg_rdata & 15'h0020, 15'h0000);
    @(posedge clk);
    @(negedge clk); tick = 0;
    reg_addr = 3'd2; #1 chk("R3 changed on third tick", reg_rdata & 15'h0020, 15'h0020);
    reg_addr = 3'd5; #1 chk("R6 status not yet set", reg_rdata & 15'h0020, 15'h0000);
    reg_we = 1; reg_wdata = 15'h0020;
    @(negedge clk); reg_we = 0;
    rd(3'd5, v); chk("R7 edge wins over clear", v & 15'h0020, 15'h0020);
    wr(3'd5, 15'h0020);
    rd(3'd5, v); chk("R7 plain clear", v, 15'h0000);

    // R4 glitch shorter than three ticks
    wr(3'd3, 15'h0020);
    @(negedge clk); tick = 1; ext[5] = 0;
    repeat (2) @(negedge clk); ext[5] = 1;
    repeat (10) @(negedge clk); tick = 0;
    rd(3'd2, v); chk("R4 glitch rejected", v & 15'h0020, 15'h0020);
    rd(3'd5, v); chk("R4 no status from glitch", v, 15'h0000);

    // R5 no ticks, no change
    @(negedge clk); ext[5] = 0;
    repeat (20) @(posedge clk);
    rd(3'd2, v); chk("R5 held without ticks", v & 15'h0020, 15'h0020);
    ticks(6);
    rd(3'd2, v); chk("R5 follows once ticking", v & 15'h0020, 15'h0000);
    rd(3'd5, v); chk("R6 falling edge sets status", v, 15'h0020);

    // R8 enable gating
    chk("R8 disabled status no irq", {14'b0, irq}, 15'h0000);
    wr(3'd4, 15'h0020);
    chk("R8 enabled status irq", {14'b0, irq}, 15'h0001);
    wr(3'd5, 15'h0020);
    chk("R8 irq drops after clear", {14'b0, irq}, 15'h0000);

    // R6 rising polarity on pin 3 does not fire on a falling edge
    wr(3'd4, 15'h0008);
    @(negedge clk); ext[3] = 1; ticks(8);
    rd(3'd5, v); chk("R6 rising edge pin 3", v, 15'h0008);
    chk("R8 irq from pin 3", {14'b0, irq}, 15'h0001);
    wr(3'd5, 15'h0008);
    @(negedge clk); ext[3] = 0; ticks(8);
    rd(3'd5, v); chk("R6 falling ignored with rising polarity", v, 15'h0000);
    finish_run();
  end
endmodule